// File: doc/BRIEF.md
# Shared Enable/Status Interrupt Aggregator

This block gathers a small group of interrupt sources, from two to seven, behind a single 32-bit control register. Each source owns one sticky pending bit and one enable bit, both held in the same register. The pending bit sits exactly 16 positions above the matching enable bit. The block drives one level-sensitive request toward a parent interrupt controller. That request stays high while any pending bit is set with its enable also set.

Software services the block through a single-cycle port. Reads are combinational and need no strobe. A write loads the whole enable field. In the same write, the status half is write-1-to-clear, so a write that only changes enables must carry zeros in the upper half. The source field can start at a bit offset other than zero. Source n then maps to register bit `FIELD_LSB+n` for its enable and to bit `FIELD_LSB+n+16` for its status. Every bit outside the two fields reads as 0.

Top module: `irq_combo_reg`

## Requirements
- R1: While reset is asserted, and just after it, every register bit reads 0 and `irq_out` is 0.
- R2: A write loads enable bit n from write bit `FIELD_LSB+n`; the read value shows it there from the next cycle on.
- R3: An asserted `src_in[n]` sets status bit n, read at bit `FIELD_LSB+n+16`, on the next edge whatever its enable.
- R4: Writing 1 to bit `FIELD_LSB+n+16` clears status bit n; writing 0 there leaves it unchanged, and status never falls without such a write.
- R5: If a source is asserted in the same cycle as a clearing write to its status bit, the bit stays 1.
- R6: `irq_out` is registered: in each cycle it equals the OR, over all sources, of status AND enable as they stood in the previous cycle.
- R7: Bits outside the enable field `[FIELD_LSB+NUM_SRC-1:FIELD_LSB]` and the status field 16 positions higher always read 0, and writes to them have no effect.
- R8: A status bit stays set after its source deasserts, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the control register |
| reg_wdata | input | 32 | Write data: enables in the lower half, write-1-to-clear status in the upper half |
| reg_rdata | output | 32 | Current register contents |
| src_in | input | NUM_SRC | Interrupt source inputs, one per source |
| irq_out | output | 1 | Registered level request to the parent controller |

## Verification
The bench builds the block with two sources at offset 4. These are the narrowest count and a non-zero field start, so fields sit at bits 5:4 and 21:20. With that setting, every bit below, between and above the fields is an unused bit that the bench can write with ones and watch read back as zero. It also makes the offset mapping and the 16-bit spacing between enable and status visible at the ports. The bench walks a vector sequence through enable-only writes, clears, disabled sources and a simultaneous set and clear, and then applies reset in the middle of a run.

// File: rtl/irq_combo_reg.sv
module irq_combo_reg #(
  parameter int NUM_SRC   = 7,
  parameter int FIELD_LSB = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_out
);
  localparam int STAT_LSB = FIELD_LSB + 16;

  logic [NUM_SRC-1:0] en_q, st_q, clr;

  assign clr = reg_we ? reg_wdata[STAT_LSB +: NUM_SRC] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      st_q    <= '0;
      irq_out <= 1'b0;
    end else begin
      if (reg_we) en_q <= reg_wdata[FIELD_LSB +: NUM_SRC];
      st_q    <= (st_q & ~clr) | src_in;
      irq_out <= |(st_q & en_q);
    end
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[FIELD_LSB +: NUM_SRC] = en_q;
    reg_rdata[STAT_LSB  +: NUM_SRC] = st_q;
  end
endmodule

// File: rtl/irq_combo_reg_chk.sv
module irq_combo_reg_chk #(
  parameter int NUM_SRC   = 7,
  parameter int FIELD_LSB = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_we,
  input logic [31:0]        reg_wdata,
  input logic [31:0]        reg_rdata,
  input logic [NUM_SRC-1:0] src_in,
  input logic               irq_out
);
  localparam int STAT_LSB = FIELD_LSB + 16;
  localparam logic [31:0] USED =
    ({{(32-NUM_SRC){1'b0}}, {NUM_SRC{1'b1}}} << FIELD_LSB) |
    ({{(32-NUM_SRC){1'b0}}, {NUM_SRC{1'b1}}} << STAT_LSB);

  logic [NUM_SRC-1:0] en_v, st_v;
  assign en_v = reg_rdata[FIELD_LSB +: NUM_SRC];
  assign st_v = reg_rdata[STAT_LSB  +: NUM_SRC];

  always @(posedge clk)
    if (!rst_n) assert_reset_clear_R1: assert (reg_rdata == 32'h0);

  assert_enable_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> en_v == $past(reg_wdata[FIELD_LSB +: NUM_SRC]));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_in) |=> (st_v & $past(src_in)) == $past(src_in));

  assert_no_spurious_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (($past(st_v) & ~st_v & ~($past(reg_we) ? $past(reg_wdata[STAT_LSB +: NUM_SRC]) : '0)) == '0));

  assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (irq_out == $past(|(st_v & en_v))));

  assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~USED) == 32'h0);
endmodule

bind irq_combo_reg irq_combo_reg_chk #(.NUM_SRC(NUM_SRC), .FIELD_LSB(FIELD_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .src_in(src_in), .irq_out(irq_out));

// File: tb/sim_irq_combo_reg.sv
module sim_irq_combo_reg;
  localparam int N = 2;
  localparam int NV = 14;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [31:0] wd = '0, rd;
  logic [N-1:0] src = '0;
  logic irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_combo_reg #(.NUM_SRC(N), .FIELD_LSB(4)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_wdata(wd),
    .reg_rdata(rd), .src_in(src), .irq_out(irq));

  // {we, wdata, src, expected rdata after edge, expected irq after edge}
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 32'h0000_FFFF, 2'b00, 32'h0000_0030, 1'b0}, // R2
    {1'b0, 32'h0,         2'b01, 32'h0010_0030, 1'b0}, // R3
    {1'b0, 32'h0,         2'b00, 32'h0010_0030, 1'b1}, // R6 R8
    {1'b1, 32'h0000_0010, 2'b00, 32'h0010_0010, 1'b1}, // R4 zero leaves
    {1'b1, 32'h0010_0010, 2'b00, 32'h0000_0010, 1'b1}, // R4 clear
    {1'b0, 32'h0,         2'b00, 32'h0000_0010, 1'b0}, // R6
    {1'b0, 32'h0,         2'b10, 32'h0020_0010, 1'b0}, // R3 disabled
    {1'b0, 32'h0,         2'b00, 32'h0020_0010, 1'b0}, // R6 gated
    {1'b1, 32'h0000_0020, 2'b00, 32'h0020_0020, 1'b0}, // R2
    {1'b0, 32'h0,         2'b00, 32'h0020_0020, 1'b1}, // R6
    {1'b1, 32'h0020_0020, 2'b10, 32'h0020_0020, 1'b1}, // R5
    {1'b1, 32'hFFCF_FFCF, 2'b00, 32'h0020_0000, 1'b1}, // R7
    {1'b0, 32'h0,         2'b00, 32'h0020_0000, 1'b0}, // R6
    {1'b1, 32'h0030_0000, 2'b00, 32'h0000_0000, 1'b0}  // R4
  };

  task automatic check(input string req, input logic [31:0] exp_rd, input logic exp_irq);
    total++;
    if (rd !== exp_rd || irq !== exp_irq) begin
      bad++;
      $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", req, rd, irq, exp_rd, exp_irq);
    end
  endtask

  task automatic step(input logic w, input logic [31:0] d, input logic [N-1:0] s);
    @(negedge clk);
    we = w; wd = d; src = s;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; wd = '0; src = '0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", 32'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][67], VEC[i][66:35], VEC[i][34:33]);
      check($sformatf("vector %0d (R2-R8 table)", i), VEC[i][32:1], VEC[i][0]);
    end

    // R8: status held long after source drops, R6 stays high
    step(1'b1, 32'h0000_0030, 2'b11);
    repeat (4) step(1'b0, 32'h0, 2'b00);
    check("R8 sticky", 32'h0030_0030, 1'b1);

    // R7: all-ones write touches only the fields
    step(1'b1, 32'hFFFF_FFFF, 2'b00);
    check("R7 all ones", 32'h0000_0030, 1'b1);
    step(1'b0, 32'h0, 2'b00);
    check("R4 R6 cleared", 32'h0000_0030, 1'b0);

    // R1: reset in the middle of activity
    step(1'b0, 32'h0, 2'b01);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after second reset", 32'h0, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule